// File: doc/BRIEF.md
# Q-format convert/pack unit

This block is a fixed-point conversion and packing datapath for a 64-bit vector unit. Each cycle it takes an operation code, two 64-bit source operands and the old contents of the destination. It produces a 64-bit result, a flag that reports whether any lane was clamped, and a flag for an unused operation code.

The operations fall into three groups. Widening converts move a short signed lane into a longer Q format by sign extension and a left shift. Narrowing converts round a long value into a shorter Q format and saturate it. They write only the low lane of the destination and pass the rest of the old destination value through. Packing operations narrow several lanes taken from both sources and lay them side by side in one word.

With `REG_OUT` = 1 (the default), the result and both flags are registered, so the outputs show the inputs of the previous clock cycle. With `REG_OUT` = 0 the outputs are combinational.

Top module: `qfmt_conv_unit`

## Requirements
- R1: With op code 0, the result is bits 15:0 of source A read as a signed 16-bit value, sign-extended to 64 bits and multiplied by 2^15.
- R2: With op code 1, the result is bits 31:0 of source A read as a signed 32-bit value, sign-extended to 64 bits and multiplied by 2^31.
- R3: With op code 2, source A is a signed 64-bit value. It is rounded and shifted right by 15 bits, then saturated to signed 16 bits, and the result is written to bits 15:0. Bits 63:16 of the result equal the old destination input.
- R4: With op code 3, source A is rounded and shifted right by 31 bits, then saturated to signed 32 bits, and the result is written to bits 31:0. Bits 63:32 of the result equal the old destination input.
- R5: With op code 4, each signed 32-bit word is rounded and shifted right by 16 bits, then saturated to signed 16 bits. The halfwords are filled as follows: source A bits 31:0 go to result bits 15:0, source A bits 63:32 go to bits 31:16, source B bits 31:0 go to bits 47:32, and source B bits 63:32 go to bits 63:48.
- R6: With op code 5, each signed 64-bit source is doubled exactly, with no overflow, then saturated to signed 32 bits. Source A goes to result bits 31:0 and source B goes to bits 63:32.
- R7: With op code 6, each signed 64-bit source is saturated to signed 32 bits. Source A goes to result bits 31:0 and source B goes to bits 63:32.
- R8: Rounding adds one half of the retained LSB and then floors. An exact half therefore rounds toward positive infinity: +0.5 LSB gives 1, -0.5 LSB gives 0, and -1.5 LSB gives -1.
- R9: Saturation clamps a lane to the largest or smallest value of its target width. The saturation output is high exactly when at least one lane of the current operation was clamped. It is always low for op codes 0 and 1.
- R10: Op code 7 gives an all-zero result with the illegal-op output high and the saturation output low. Every other code drives the illegal-op output low.
- R11: With `REG_OUT` = 1, the outputs change only at a rising clock edge and show the inputs that were present before that edge. An active-low reset clears the result and both flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0..7) |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand |
| dst_old_i | input | 64 | Previous destination value, kept in part by the narrowing ops |
| result_o | output | 64 | Converted or packed result |
| sat_o | output | 1 | At least one lane clamped |
| illegal_o | output | 1 | Unused operation code |

## Verification
The hardest cases to reach are the lanes that land exactly on a rounding tie or on the edge of the saturation range. Examples are a word that rounds up to exactly 0x8000 and must then clamp, and a negative half-LSB that must round to zero without raising the flag. Random operands almost never hit these points. The bench therefore builds its operand set from sixteen hand-picked 64-bit values that straddle every lane boundary in both halves of the word. It applies every pairing of these values under all eight op codes, with an old-destination pattern derived from both operands so that the bits passed through are distinct in every vector.

// File: rtl/qfmt_pkg.sv
package qfmt_pkg;
  localparam int XLEN  = 64;
  localparam int WORD  = 32;
  localparam int HALF  = 16;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_W15_30 = 3'd0,
    OP_W31_62 = 3'd1,
    OP_N30_15 = 3'd2,
    OP_N62_31 = 3'd3,
    OP_P31_15 = 3'd4,
    OP_P30_31 = 3'd5,
    OP_P64_32 = 3'd6,
    OP_BAD    = 3'd7
  } qop_e;
endpackage

// File: rtl/qfmt_widen.sv
module qfmt_widen #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 64,
  parameter int SHIFT = 15
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int PAD = OUT_W - IN_W;

  logic [OUT_W-1:0] ext;

  assign ext   = {{PAD{val_i[IN_W-1]}}, val_i};
  assign val_o = ext << SHIFT;
endmodule

// File: rtl/qfmt_rnd_sat.sv
module qfmt_rnd_sat #(
  parameter int IN_W  = 64,
  parameter int SHIFT = 15,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o,
  output logic             clamp_o
);
  localparam int EW = IN_W + 1;
  localparam logic signed [EW-1:0] MAXV = {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = ~MAXV;

  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] scaled;
  logic                 over_hi;
  logic                 over_lo;

  assign ext = {val_i[IN_W-1], val_i};

  generate
    if (SHIFT > 0) begin : g_round
      localparam logic signed [EW-1:0] BIAS = EW'(1) << (SHIFT - 1);
      logic signed [EW-1:0] biased;
      // half-LSB bias then floor: ties go toward +inf
      assign biased = ext + BIAS;
      assign scaled = biased >>> SHIFT;
    end else begin : g_pass
      assign scaled = ext;
    end
  endgenerate

  assign over_hi = scaled > MAXV;
  assign over_lo = scaled < MINV;
  assign clamp_o = over_hi | over_lo;

  always_comb begin
    if (over_hi)      val_o = MAXV[OUT_W-1:0];
    else if (over_lo) val_o = MINV[OUT_W-1:0];
    else              val_o = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/qfmt_conv_unit.sv
module qfmt_conv_unit
  import qfmt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [XLEN-1:0] dst_old_i,
  output logic [XLEN-1:0] result_o,
  output logic            sat_o,
  output logic            illegal_o
);
  localparam int N_HL = (2 * XLEN) / WORD;
  localparam int N_WL = (2 * XLEN) / XLEN;
  localparam logic [XLEN-1:0] KEEP_H = ~{{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [XLEN-1:0] KEEP_W = ~{{(XLEN-WORD){1'b0}}, {WORD{1'b1}}};

  qop_e              op;
  logic [2*XLEN-1:0] pair;
  logic [XLEN-1:0]   w15_res, w31_res;
  logic [HALF-1:0]   n15_res;
  logic [WORD-1:0]   n31_res;
  logic              n15_clp, n31_clp;
  logic [N_HL*HALF-1:0] p15_res;
  logic [N_HL-1:0]      p15_clp;
  logic [N_WL*WORD-1:0] p31_res, pi_res;
  logic [N_WL-1:0]      p31_clp, pi_clp;

  logic [XLEN-1:0] res_d;
  logic            sat_d;
  logic            ill_d;

  assign op   = qop_e'(op_i);
  assign pair = {src_b_i, src_a_i};

  qfmt_widen #(.IN_W(HALF), .OUT_W(XLEN), .SHIFT(HALF-1)) u_w15 (
    .val_i(src_a_i[HALF-1:0]), .val_o(w15_res));
  qfmt_widen #(.IN_W(WORD), .OUT_W(XLEN), .SHIFT(WORD-1)) u_w31 (
    .val_i(src_a_i[WORD-1:0]), .val_o(w31_res));

  qfmt_rnd_sat #(.IN_W(XLEN), .SHIFT(HALF-1), .OUT_W(HALF)) u_n15 (
    .val_i(src_a_i), .val_o(n15_res), .clamp_o(n15_clp));
  qfmt_rnd_sat #(.IN_W(XLEN), .SHIFT(WORD-1), .OUT_W(WORD)) u_n31 (
    .val_i(src_a_i), .val_o(n31_res), .clamp_o(n31_clp));

  generate
    for (genvar k = 0; k < N_HL; k++) begin : g_p15
      qfmt_rnd_sat #(.IN_W(WORD), .SHIFT(HALF), .OUT_W(HALF)) u_lane (
        .val_i  (pair[k*WORD +: WORD]),
        .val_o  (p15_res[k*HALF +: HALF]),
        .clamp_o(p15_clp[k]));
    end
    for (genvar k = 0; k < N_WL; k++) begin : g_pw
      // exact doubling: one extra bit carries the sign
      qfmt_rnd_sat #(.IN_W(XLEN+1), .SHIFT(0), .OUT_W(WORD)) u_dbl (
        .val_i  ({pair[k*XLEN +: XLEN], 1'b0}),
        .val_o  (p31_res[k*WORD +: WORD]),
        .clamp_o(p31_clp[k]));
      qfmt_rnd_sat #(.IN_W(XLEN), .SHIFT(0), .OUT_W(WORD)) u_int (
        .val_i  (pair[k*XLEN +: XLEN]),
        .val_o  (pi_res[k*WORD +: WORD]),
        .clamp_o(pi_clp[k]));
    end
  endgenerate

  always_comb begin
    res_d = '0;
    sat_d = 1'b0;
    ill_d = 1'b0;
    unique case (op)
      OP_W15_30: res_d = w15_res;
      OP_W31_62: res_d = w31_res;
      OP_N30_15: begin
        res_d = (dst_old_i & KEEP_H) | {{(XLEN-HALF){1'b0}}, n15_res};
        sat_d = n15_clp;
      end
      OP_N62_31: begin
        res_d = (dst_old_i & KEEP_W) | {{(XLEN-WORD){1'b0}}, n31_res};
        sat_d = n31_clp;
      end
      OP_P31_15: begin
        res_d = p15_res;
        sat_d = |p15_clp;
      end
      OP_P30_31: begin
        res_d = p31_res;
        sat_d = |p31_clp;
      end
      OP_P64_32: begin
        res_d = pi_res;
        sat_d = |pi_clp;
      end
      default: ill_d = 1'b1;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          result_o  <= '0;
          sat_o     <= 1'b0;
          illegal_o <= 1'b0;
        end else begin
          result_o  <= res_d;
          sat_o     <= sat_d;
          illegal_o <= ill_d;
        end
      end

      AST_ILLEGAL_FROM_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(illegal_o) |-> ($past(op_i) == OP_BAD)); // R11
    end else begin : g_comb
      assign result_o  = res_d;
      assign sat_o     = sat_d;
      assign illegal_o = ill_d;
    end
  endgenerate

  AST_N15_KEEPS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_N30_15) |-> (res_d[XLEN-1:HALF] == dst_old_i[XLEN-1:HALF])); // R3
  AST_N31_KEEPS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_N62_31) |-> (res_d[XLEN-1:WORD] == dst_old_i[XLEN-1:WORD])); // R4
  AST_BAD_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_BAD) |-> (res_d == '0 && ill_d && !sat_d)); // R10
  AST_WIDEN_NO_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_W15_30 || op_i == OP_W31_62) |-> !sat_d); // R9
  AST_P64_POS_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_P64_32 && $signed(src_a_i) > 64'sh7fff_ffff)
      |-> (res_d[WORD-1:0] == 32'h7fff_ffff && sat_d)); // R7
  AST_HALF_TIE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_N30_15 && src_a_i == 64'h4000) |-> (res_d[HALF-1:0] == 16'h0001)); // R8
endmodule

// File: tb/sim_qfmt_conv_unit.sv
module sim_qfmt_conv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_s = 3'd0;
  logic [63:0] a_s = '0, b_s = '0, d_s = '0;
  logic [63:0] res_w;
  logic        sat_w, ill_w;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  qfmt_conv_unit #(.REG_OUT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op_s), .src_a_i(a_s), .src_b_i(b_s),
    .dst_old_i(d_s), .result_o(res_w), .sat_o(sat_w), .illegal_o(ill_w));

  function automatic logic [63:0] pick(input int i);
    case (i)
      0:  pick = 64'h0;
      1:  pick = 64'h1;
      2:  pick = 64'hffff_ffff_ffff_ffff;
      3:  pick = 64'h0000_0000_0000_4000;
      4:  pick = 64'hffff_ffff_ffff_c000;
      5:  pick = 64'hffff_ffff_ffff_4000;
      6:  pick = 64'h0000_0000_7fff_ffff;
      7:  pick = 64'hffff_ffff_8000_0000;
      8:  pick = 64'h0000_0000_8000_0000;
      9:  pick = 64'h7fff_ffff_ffff_ffff;
      10: pick = 64'h8000_0000_0000_0000;
      11: pick = 64'h0000_4000_ffff_c000;
      12: pick = 64'h1234_5678_9abc_def0;
      13: pick = 64'h7fff_8000_3fff_c000;
      14: pick = 64'h0000_0000_4000_0000;
      default: pick = 64'hbfff_ffff_c000_0000;
    endcase
  endfunction

  function automatic logic [63:0] rs(input logic signed [127:0] v, input int sh,
                                     input int w, inout logic c);
    logic signed [127:0] q, mx, mn;
    logic [63:0] m;
    if (sh > 0) q = (v + (128'sd1 <<< (sh - 1))) >>> sh;
    else        q = v;
    mx = (128'sd1 <<< (w - 1)) - 128'sd1;
    mn = -(128'sd1 <<< (w - 1));
    if (q > mx)      begin c = 1'b1; q = mx; end
    else if (q < mn) begin c = 1'b1; q = mn; end
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    return q[63:0] & m;
  endfunction

  function automatic void model(input logic [2:0] op, input logic [63:0] a, b, d,
                                output logic [63:0] r, output logic s, output logic il);
    logic signed [127:0] t;
    logic [63:0] lo;
    logic [31:0] ln;
    r = '0; s = 1'b0; il = 1'b0;
    case (op)
      3'd0: begin t = $signed(a[15:0]); t = t * 128'sd32768; r = t[63:0]; end
      3'd1: begin t = $signed(a[31:0]); t = t * (128'sd1 <<< 31); r = t[63:0]; end
      3'd2: begin t = $signed(a); lo = rs(t, 15, 16, s); r = {d[63:16], lo[15:0]}; end
      3'd3: begin t = $signed(a); lo = rs(t, 31, 32, s); r = {d[63:32], lo[31:0]}; end
      3'd4: for (int k = 0; k < 4; k++) begin
              ln = (k < 2) ? a[32*k +: 32] : b[32*(k-2) +: 32];
              t = $signed(ln);
              lo = rs(t, 16, 16, s);
              r[16*k +: 16] = lo[15:0];
            end
      3'd5: begin
              t = $signed(a); t = t * 128'sd2; lo = rs(t, 0, 32, s); r[31:0] = lo[31:0];
              t = $signed(b); t = t * 128'sd2; lo = rs(t, 0, 32, s); r[63:32] = lo[31:0];
            end
      3'd6: begin
              t = $signed(a); lo = rs(t, 0, 32, s); r[31:0] = lo[31:0];
              t = $signed(b); lo = rs(t, 0, 32, s); r[63:32] = lo[31:0];
            end
      default: il = 1'b1;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: req_of = "R1"; 3'd1: req_of = "R2"; 3'd2: req_of = "R3";
      3'd3: req_of = "R4"; 3'd4: req_of = "R5"; 3'd5: req_of = "R6";
      3'd6: req_of = "R7"; default: req_of = "R10";
    endcase
  endfunction

  task automatic expect_out(input string rq, input logic [63:0] er, input logic es, input logic ei);
    n_chk++;
    if (res_w !== er || sat_w !== es || ill_w !== ei) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: got res=%h sat=%b ill=%b, exp res=%h sat=%b ill=%b",
               rq, op_s, a_s, b_s, res_w, sat_w, ill_w, er, es, ei);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [63:0] a, b, d, input string tag);
    logic [63:0] er;
    logic es, ei;
    @(negedge clk);
    op_s = op; a_s = a; b_s = b; d_s = d;
    model(op, a, b, d, er, es, ei);
    @(negedge clk);
    expect_out(tag, er, es, ei);
    if (es) expect_out("R9", er, 1'b1, ei);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    op_s = 3'd7; a_s = '1; b_s = '1;
    repeat (3) @(negedge clk);
    expect_out("R11", 64'h0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // R8 tie cases
    apply(3'd2, 64'h0000_0000_0000_4000, 64'h0, 64'h0, "R8");
    apply(3'd2, 64'hffff_ffff_ffff_c000, 64'h0, 64'h0, "R8");
    apply(3'd2, 64'hffff_ffff_ffff_4000, 64'h0, 64'h0, "R8");
    apply(3'd4, 64'h0000_8000_ffff_8000, 64'h0, 64'h0, "R8");
    n_chk++;
    if (res_w[15:0] !== 16'h0000 || res_w[31:16] !== 16'h0001) begin
      n_bad++;
      $display("FAIL R8 tie lanes got %h exp 0001_0000", res_w[31:0]);
    end

    // R11: output holds until the edge
    apply(3'd6, 64'h5, 64'h6, 64'h0, "R7");
    held = res_w;
    @(negedge clk);
    op_s = 3'd7;
    #2;
    n_chk++;
    if (res_w !== held || ill_w !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 early change got %h/%b exp %h/0", res_w, ill_w, held);
    end
    @(negedge clk);
    expect_out("R11", 64'h0, 1'b0, 1'b1);

    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          apply(3'(op), pick(i), pick(j),
                {pick(j)[31:0], pick(i)[63:32]} ^ 64'ha5c3_96f0_0f69_3c5a, req_of(3'(op)));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule